// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two 2-bit counter predictors work side by side. One keeps a counter per branch address and never looks at history. The other folds a global shift register of recent outcomes into its index, so it can learn patterns that span several branches. A per-address chooser table learns which of the two has been right more often for that branch, and the final direction comes from the component it favours.

The fetch side presents a branch address on the lookup port. In the same cycle it receives the final direction and the two component directions. It keeps the two component directions with the branch. When the branch resolves, the back end presents the address, the real outcome and those two saved directions on the update port. Only then do the tables train and the history shift. Nothing is updated speculatively. The table depth is set by an index-width parameter. A width of 13 gives 8K entries per table, and smaller widths give cheaper configurations.

Top module: `tourney_pred`

## Requirements
- R1: After reset every counter in the address table and the history table holds 1 (weakly not-taken), every chooser entry holds 1 (leaning to the address table), and the history register is zero. As a result, every lookup returns not-taken for all three outputs.
- R2: Every counter is 2 bits wide and reads as taken when its value is 2 or 3. A taken outcome adds one and a not-taken outcome subtracts one. The value saturates at 3 and at 0.
- R3: The address table and the chooser are indexed by PC bits [PC_LSB+IDX_W-1 : PC_LSB].
- R4: The history table is indexed by the R3 index XOR the IDX_W-bit history register. On each accepted update the history shifts left by one, and the outcome enters bit 0.
- R5: `lk_taken` equals `lk_glob_taken` when the chooser entry is 2 or 3, and equals `lk_loc_taken` otherwise.
- R6: The chooser entry for the updated address counts up when only the captured history-table direction matched the outcome. It counts down when only the captured address-table direction matched. It does not change when both matched or neither did. It saturates as in R2.
- R7: A lookup in the same cycle as an update returns the table contents from before that update. The update is visible to lookups from the next cycle on.
- R8: While `upd_valid` is low, the values on the other update inputs have no effect on any table or on the history register.
- R9: `lk_taken` always equals at least one of the two component directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_taken | output | 1 | Final predicted direction (1 = taken) |
| lk_glob_taken | output | 1 | Direction from the history-indexed table |
| lk_loc_taken | output | 1 | Direction from the address-indexed table |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_glob_taken | input | 1 | History-table direction captured at lookup |
| upd_loc_taken | input | 1 | Address-table direction captured at lookup |

## Verification
The bench builds the block with IDX_W = 4 and PC_LSB = 2, so each table has only 16 entries. The history register therefore wraps after four outcomes. Two addresses 0x400 apart land on the same entry, which makes aliasing between branches and history-driven index changes appear within a few dozen updates. Saturation at both ends, chooser movement and the chooser switching from one component to the other all appear inside a short run. A behavioural model in the bench predicts every lookup output.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_MIN = 2'd0;
    localparam ctr_t CTR_MAX = 2'd3;
    localparam ctr_t CTR_WEAK_NT = 2'd1;

    // Saturating step of a 2-bit counter
    function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
        ctr_t nxt;
        if (up) begin
            nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
        end else begin
            nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
        end
        return nxt;
    endfunction

    // Upper half of the range reads as taken
    function automatic logic ctr_dir(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
    import tp_pkg::*;
#(
    parameter int   IDX_W = 10,
    parameter ctr_t INIT  = CTR_WEAK_NT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_t ctr_q [DEPTH];
    ctr_t ctr_d [DEPTH];

    // Read sees the registered contents, so a write in the same cycle is not visible yet
    assign rd_ctr = ctr_q[rd_idx];

    always_comb begin
        ctr_d = ctr_q;
        if (wr_en) begin
            ctr_d[wr_idx] = ctr_step(ctr_q[wr_idx], wr_up);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr_q[i] <= INIT;
            end
        end else begin
            ctr_q <= ctr_d;
        end
    end

    // R2
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && ctr_q[wr_idx] == CTR_MAX) |=> ctr_q[$past(wr_idx)] == CTR_MAX);

    // R2
    sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && ctr_q[wr_idx] == CTR_MIN) |=> ctr_q[$past(wr_idx)] == CTR_MIN);

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && ctr_q[wr_idx] != CTR_MAX)
        |=> ctr_q[$past(wr_idx)] == $past(ctr_q[wr_idx]) + 2'd1);

endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] hist
);

    logic [W-1:0] hist_d;
    logic [W-1:0] hist_q;

    always_comb begin
        hist_d = hist_q;
        if (shift_en) begin
            hist_d = {hist_q[W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist = hist_q;

    // R4
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist_q[0] == $past(bit_in)) && (hist_q[W-1:1] == $past(hist_q[W-2:0])));

    // R8
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
    import tp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic            lk_glob_taken,
    output logic            lk_loc_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_glob_taken,
    input  logic            upd_loc_taken
);

    logic [IDX_W-1:0] hist;
    logic [IDX_W-1:0] lk_loc_idx, lk_glob_idx;
    logic [IDX_W-1:0] up_loc_idx, up_glob_idx;
    ctr_t             glob_ctr, loc_ctr, sel_ctr;
    logic             glob_ok, loc_ok, sel_wr;

    // R3 and R4 index forming
    assign lk_loc_idx  = lk_pc[PC_LSB +: IDX_W];
    assign lk_glob_idx = lk_loc_idx ^ hist;
    assign up_loc_idx  = upd_pc[PC_LSB +: IDX_W];
    assign up_glob_idx = up_loc_idx ^ hist;

    assign glob_ok = (upd_glob_taken == upd_taken);
    assign loc_ok  = (upd_loc_taken == upd_taken);
    assign sel_wr  = upd_valid && (glob_ok != loc_ok);

    tp_ctr_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_NT)) u_glob_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_glob_idx),
        .rd_ctr (glob_ctr),
        .wr_en  (upd_valid),
        .wr_idx (up_glob_idx),
        .wr_up  (upd_taken)
    );

    tp_ctr_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_NT)) u_loc_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_loc_idx),
        .rd_ctr (loc_ctr),
        .wr_en  (upd_valid),
        .wr_idx (up_loc_idx),
        .wr_up  (upd_taken)
    );

    // Chooser: high half favours the history table
    tp_ctr_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_NT)) u_sel_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_loc_idx),
        .rd_ctr (sel_ctr),
        .wr_en  (sel_wr),
        .wr_idx (up_loc_idx),
        .wr_up  (glob_ok)
    );

    tp_ghist #(.W(IDX_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .bit_in   (upd_taken),
        .hist     (hist)
    );

    always_comb begin
        lk_glob_taken = ctr_dir(glob_ctr);
        lk_loc_taken  = ctr_dir(loc_ctr);
        lk_taken      = ctr_dir(sel_ctr) ? lk_glob_taken : lk_loc_taken;
    end

    // R9
    pick_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_taken == lk_glob_taken) || (lk_taken == lk_loc_taken));

    // R5
    agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_glob_taken == lk_loc_taken) |-> (lk_taken == lk_loc_taken));

endmodule

// File: tb/tourney_pred_tb.sv
module tourney_pred_tb;

    localparam int PC_W   = 32;
    localparam int PC_LSB = 2;
    localparam int IDX_W  = 4;
    localparam int N      = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_taken, lk_glob_taken, lk_loc_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic            upd_glob_taken = 1'b0;
    logic            upd_loc_taken = 1'b0;

    always #4 clk = ~clk;

    tourney_pred #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .lk_pc          (lk_pc),
        .lk_taken       (lk_taken),
        .lk_glob_taken  (lk_glob_taken),
        .lk_loc_taken   (lk_loc_taken),
        .upd_valid      (upd_valid),
        .upd_pc         (upd_pc),
        .upd_taken      (upd_taken),
        .upd_glob_taken (upd_glob_taken),
        .upd_loc_taken  (upd_loc_taken)
    );

    typedef struct packed {
        logic [31:0] pc;
        logic        tk;
    } vec_t;

    // Same-entry pairs (0x40/0x440), saturation runs, alternation
    localparam vec_t VECS [20] = '{
        '{32'h0000_0040, 1'b1}, '{32'h0000_0040, 1'b1}, '{32'h0000_0040, 1'b1},
        '{32'h0000_0040, 1'b1}, '{32'h0000_0040, 1'b1}, '{32'h0000_0440, 1'b0},
        '{32'h0000_0440, 1'b0}, '{32'h0000_0080, 1'b1}, '{32'h0000_0080, 1'b0},
        '{32'h0000_0080, 1'b1}, '{32'h0000_0080, 1'b0}, '{32'h0000_0084, 1'b0},
        '{32'h0000_0084, 1'b0}, '{32'h0000_0084, 1'b0}, '{32'h0000_0084, 1'b0},
        '{32'h0000_003c, 1'b1}, '{32'h0000_0000, 1'b1}, '{32'h0000_0040, 1'b0},
        '{32'h0000_0440, 1'b1}, '{32'h0000_003c, 1'b0}
    };

    int m_g [N];
    int m_l [N];
    int m_c [N];
    int m_h;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic int step(input int v, input bit up);
        if (up) return (v == 3) ? 3 : v + 1;
        return (v == 0) ? 0 : v - 1;
    endfunction

    function automatic int lidx(input logic [31:0] pc);
        return int'(pc[PC_LSB +: IDX_W]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_g[i] = 1; m_l[i] = 1; m_c[i] = 1;
        end
        m_h = 0;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Compare all lookup outputs with the model for the current lk_pc
    task automatic check_lookup(input string req);
        int li, gi;
        bit eg, el, ef;
        li = lidx(lk_pc);
        gi = li ^ m_h;
        eg = (m_g[gi] >= 2);
        el = (m_l[li] >= 2);
        ef = (m_c[li] >= 2) ? eg : el;
        chk(lk_glob_taken == eg, {req, " glob"}, lk_glob_taken, eg);
        chk(lk_loc_taken == el, {req, " loc"}, lk_loc_taken, el);
        chk(lk_taken == ef, {req, " final"}, lk_taken, ef);
    endtask

    task automatic model_update(input logic [31:0] pc, input bit tk, input bit gp, input bit lp);
        int li, gi;
        li = lidx(pc);
        gi = li ^ m_h;
        if ((gp == tk) != (lp == tk)) m_c[li] = step(m_c[li], gp == tk);
        m_g[gi] = step(m_g[gi], tk);
        m_l[li] = step(m_l[li], tk);
        m_h = ((m_h << 1) | int'(tk)) & (N - 1);
    endtask

    // Lookup and resolve one branch in the same cycle (R7: lookup sees pre-update state)
    task automatic run_branch(input logic [31:0] pc, input bit tk, input string req);
        @(negedge clk);
        lk_pc = pc;
        #1;
        check_lookup(req);
        upd_pc = pc;
        upd_taken = tk;
        upd_glob_taken = lk_glob_taken;
        upd_loc_taken = lk_loc_taken;
        upd_valid = 1'b1;
        #1;
        check_lookup("R7 same-cycle");
        @(posedge clk);
        model_update(pc, tk, upd_glob_taken, upd_loc_taken);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic probe_all(input string req);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            lk_pc = 32'(i) << PC_LSB;
            #1;
            check_lookup(req);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every entry predicts not-taken after reset
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            lk_pc = 32'(i) << PC_LSB;
            #1;
            chk(lk_taken == 1'b0 && lk_glob_taken == 1'b0 && lk_loc_taken == 1'b0,
                "R1 reset state", {lk_taken, lk_glob_taken, lk_loc_taken}, 0);
        end

        // Vector table: R2 R3 R4 R5 R6 through the model
        for (int v = 0; v < 20; v++) begin
            run_branch(VECS[v].pc, VECS[v].tk, "R3 R4 R5 vector");
        end
        probe_all("R2 R6 table sweep");

        // R8: junk on the update inputs with valid low changes nothing
        @(negedge clk);
        upd_valid = 1'b0;
        upd_pc = 32'h0000_0040;
        upd_taken = 1'b1;
        upd_glob_taken = 1'b0;
        upd_loc_taken = 1'b1;
        repeat (4) @(posedge clk);
        probe_all("R8 valid low");

        // R2 saturation at the bottom then the top for one address
        for (int k = 0; k < 6; k++) run_branch(32'h0000_0104, 1'b0, "R2 down");
        for (int k = 0; k < 6; k++) run_branch(32'h0000_0104, 1'b1, "R2 up");

        // R6 R5: alternating branch, history learns it and chooser moves toward it
        for (int k = 0; k < 40; k++) run_branch(32'h0000_0208, k[0], "R6 alternate");
        probe_all("R6 chooser sweep");

        // Mixed pattern: two interleaved branches with correlated outcomes
        for (int k = 0; k < 30; k++) begin
            run_branch(32'h0000_0010, k[1], "R4 corr a");
            run_branch(32'h0000_0414, k[1], "R4 corr b");
        end

        // R1: reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        probe_all("R1 re-reset");

        finish_run();
    end

endmodule